// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, every cycle, which of several hardware thread contexts feeds the next instruction into a shared pipeline. Each context owns a private program counter. The selector reports the chosen thread number, that thread's program counter and a flag that says whether an instruction may issue this cycle.

A registered mode input selects one of two switching policies. In interleaved mode, selection rotates to a new thread every cycle and skips any thread that is stalled. In sticky mode, the current thread keeps the pipeline. A short stall only makes the pipeline wait. The selector moves to another thread only when the current one reports a long-latency event. Long-latency events are held in a per-thread flag until a matching clear arrives. Each thread's program counter either steps forward when that thread issues or is loaded from a redirect input.

Top module: `thread_issue_sel`

## Requirements
- R1: After reset every thread's PC equals `RST_PC`. When a thread issues and is not redirected in that cycle, its PC grows by `PC_INC` at the next clock edge.
- R2: When `redirect_en[i]` is high, the PC of thread i is loaded from slice i of `redirect_pc` (bits i*PCW and up) at the next edge. This takes priority over the issue step.
- R3: In interleaved mode (registered mode 0), the search starts at the thread after the last selected one and wraps around. The first thread whose `short_stall` is low and that is not long-stalled is chosen, and `issue_valid` is high.
- R4: If no thread is eligible, `issue_valid` is low and `issue_tid` keeps the last selected thread.
- R5: In sticky mode (registered mode 1), a thread that is not long-stalled stays selected. If its `short_stall` is high, `issue_valid` is low for that cycle and no switch takes place.
- R6: In sticky mode, when the current thread is long-stalled, the search starts after it and picks the first thread that is not long-stalled, ignoring short stalls. `issue_valid` then equals the inverse of that thread's `short_stall`. If every thread is long-stalled, `issue_valid` is low.
- R7: A thread counts as long-stalled from the cycle its `long_set` bit is high until the cycle its `long_clr` bit is high. A clear takes effect in the cycle it is asserted. If set and clear arrive together, set wins.
- R8: A change on `coarse_mode` changes the policy one cycle later.
- R9: Out of reset the mode is interleaved, no thread is long-stalled, and the last-selected pointer is thread NTHR-1, so thread 0 is picked first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coarse_mode | input | 1 | 0 interleaved, 1 sticky (registered) |
| short_stall | input | NTHR | Per-thread short stall, bit i is thread i |
| long_set | input | NTHR | Per-thread long-stall event |
| long_clr | input | NTHR | Per-thread long-stall clear |
| redirect_en | input | NTHR | Per-thread PC load enable |
| redirect_pc | input | NTHR*PCW | Per-thread new PC, slice i for thread i |
| issue_tid | output | TW | Selected thread number |
| issue_pc | output | PCW | PC of the selected thread |
| issue_valid | output | 1 | Selected thread may issue this cycle |

## Verification
The bench builds the block with NTHR=4 and PCW=16, with the default step of 4. Four threads are enough to make the rotating search wrap past thread 3 and to leave one thread as the only eligible one while the others are short- or long-stalled. They also allow every thread to be long-stalled at once in sticky mode. The 16-bit program counters keep redirect values and step results easy to read. The vector table switches modes partway through, so it covers both the one-cycle mode lag and the return of a cleared thread to rotation.

// File: rtl/thread_issue_sel.sv
module thread_issue_sel #(
  parameter int NTHR   = 4,
  parameter int PCW    = 32,
  parameter int PC_INC = 4,
  parameter logic [PCW-1:0] RST_PC = '0,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                coarse_mode,
  input  logic [NTHR-1:0]     short_stall,
  input  logic [NTHR-1:0]     long_set,
  input  logic [NTHR-1:0]     long_clr,
  input  logic [NTHR-1:0]     redirect_en,
  input  logic [NTHR*PCW-1:0] redirect_pc,
  output logic [TW-1:0]       issue_tid,
  output logic [PCW-1:0]      issue_pc,
  output logic                issue_valid
);

  logic            mode_q;
  logic [TW-1:0]   cur;
  logic [NTHR-1:0] lstall;
  logic [NTHR-1:0] long_now;
  logic [NTHR-1:0] cand;
  logic [PCW-1:0]  pc_r [NTHR];
  logic [TW-1:0]   pick;
  logic            found;
  logic            hold;

  assign long_now = (lstall & ~long_clr) | long_set;
  assign hold     = mode_q && !long_now[cur];
  assign cand     = mode_q ? ~long_now : ~(long_now | short_stall);

  always_comb begin
    int j;
    found = 1'b0;
    pick  = cur;
    for (int k = 1; k <= NTHR; k++) begin
      j = (int'(cur) + k) % NTHR;
      if (!found && cand[j]) begin
        found = 1'b1;
        pick  = TW'(j);
      end
    end
  end

  assign issue_tid   = hold ? cur : pick;
  assign issue_valid = hold ? !short_stall[cur]
                     : (found && (!mode_q || !short_stall[pick]));
  assign issue_pc    = pc_r[issue_tid];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cur    <= TW'(NTHR - 1);
      lstall <= '0;
    end else begin
      mode_q <= coarse_mode;
      lstall <= long_now;
      if (!hold && found && (mode_q || issue_valid)) cur <= pick;
    end
  end

  for (genvar i = 0; i < NTHR; i++) begin : g_pc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  pc_r[i] <= RST_PC;
      else if (redirect_en[i])                     pc_r[i] <= redirect_pc[i*PCW +: PCW];
      else if (issue_valid && issue_tid == TW'(i)) pc_r[i] <= pc_r[i] + PCW'(PC_INC);
    end

    p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_tid == TW'(i) && !redirect_en[i])
        |=> pc_r[i] == $past(pc_r[i]) + PCW'(PC_INC));

    p_redirect_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_en[i] |=> pc_r[i] == $past(redirect_pc[i*PCW +: PCW]));

    p_long_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lstall[i] && !long_clr[i]) |=> lstall[i]);
  end

  p_issue_not_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !short_stall[issue_tid]);

  p_idle_all_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !issue_valid) |-> &(short_stall | long_now));

  p_sticky_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && issue_tid != cur) |=> lstall[$past(cur)]);

endmodule

// File: tb/sim_thread_issue_sel.sv
module sim_thread_issue_sel;
  localparam int NTHR = 4;
  localparam int PCW  = 16;
  localparam int TW   = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                coarse_mode = 1'b0;
  logic [NTHR-1:0]     short_stall = '0, long_set = '0, long_clr = '0, redirect_en = '0;
  logic [NTHR*PCW-1:0] redirect_pc = '0;
  logic [TW-1:0]       issue_tid;
  logic [PCW-1:0]      issue_pc;
  logic                issue_valid;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  thread_issue_sel #(.NTHR(NTHR), .PCW(PCW)) u0 (
    .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode),
    .short_stall(short_stall), .long_set(long_set), .long_clr(long_clr),
    .redirect_en(redirect_en), .redirect_pc(redirect_pc),
    .issue_tid(issue_tid), .issue_pc(issue_pc), .issue_valid(issue_valid));

  // {req[3:0], mode, short[3:0], set[3:0], clr[3:0], exp_valid, exp_tid[1:0]}
  localparam logic [19:0] VEC [24] = '{
    20'b1001_0_0000_0000_0000_1_00, // R9 first pick
    20'b0011_0_0000_0000_0000_1_01, // R3
    20'b0011_0_0100_0000_0000_1_11, // R3 skip
    20'b0011_0_0001_0000_0000_1_01, // R3 wrap+skip
    20'b0111_0_0000_0100_0000_1_11, // R7 set excludes now
    20'b0011_0_0000_0000_0000_1_00,
    20'b0011_0_0000_0000_0000_1_01,
    20'b0111_0_0000_0000_0000_1_11, // R7 still held
    20'b0100_0_1011_0000_0000_0_11, // R4 all blocked
    20'b0111_0_0010_0000_0100_1_00, // R7 clear
    20'b0011_0_0000_0000_0000_1_01,
    20'b0111_0_0000_0000_0000_1_10, // R7 back in rotation
    20'b1000_1_0000_0000_0000_1_11, // R8 mode lag
    20'b0101_1_0000_0000_0000_1_11, // R5
    20'b0101_1_1000_0000_0000_0_11, // R5 wait
    20'b0101_1_0000_0000_0000_1_11,
    20'b0110_1_0000_1000_0000_1_00, // R6 switch
    20'b0101_1_0001_0000_0000_0_00, // R5
    20'b0110_1_0010_0001_0000_0_01, // R6 switch to short-stalled
    20'b0101_1_0000_0000_0000_1_01,
    20'b0110_1_0000_0110_0000_0_01, // R6 all long
    20'b1000_0_0000_0000_1000_1_11, // R8 still sticky
    20'b1000_0_0000_0000_0000_1_11, // R8 now interleaved
    20'b0111_0_0000_0000_0111_1_00  // R7
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    coarse_mode = 1'b0; short_stall = '0; long_set = '0; long_clr = '0;
    redirect_en = '0; redirect_pc = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    #2;
    chk("R9 reset tid", int'(issue_tid), 0);
    chk("R9 reset valid", int'(issue_valid), 1);
    chk("R1 reset pc", int'(issue_pc), 0);
    for (int r = 0; r < 24; r++) begin
      if (r > 0) @(negedge clk);
      coarse_mode = VEC[r][15];
      short_stall = VEC[r][14:11];
      long_set    = VEC[r][10:7];
      long_clr    = VEC[r][6:3];
      #2;
      chk($sformatf("R%0d row %0d valid", VEC[r][19:16], r), int'(issue_valid), int'(VEC[r][2]));
      chk($sformatf("R%0d row %0d tid", VEC[r][19:16], r), int'(issue_tid), int'(VEC[r][1:0]));
    end
    @(negedge clk);
    short_stall = '0; long_set = '0; long_clr = '0; coarse_mode = 1'b0;

    do_reset();
    #2;
    chk("R1 t0 pc", int'(issue_pc), 0);
    @(negedge clk);
    redirect_en = 4'b0010;
    redirect_pc[1*PCW +: PCW] = 16'h1234;
    #2;
    chk("R3 t1 sel", int'(issue_tid), 1);
    chk("R1 t1 pc before load", int'(issue_pc), 0);
    @(negedge clk);
    redirect_en = '0;
    #2;
    chk("R3 t2 sel", int'(issue_tid), 2);
    @(negedge clk); #2;
    chk("R3 t3 sel", int'(issue_tid), 3);
    @(negedge clk); #2;
    chk("R1 t0 stepped pc", int'(issue_pc), 4);
    @(negedge clk); #2;
    chk("R2 t1 redirect beats step", int'(issue_pc), 16'h1234);
    @(negedge clk); #2;
    chk("R1 t2 stepped pc", int'(issue_pc), 4);
    @(negedge clk); #2;
    chk("R1 t3 stepped pc", int'(issue_pc), 4);
    @(negedge clk); #2;
    chk("R1 t0 second step", int'(issue_pc), 8);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule